// File: doc/BRIEF.md
# Codec Verb-Table Initialization Sequencer

This block replaces boot firmware for one job: bringing attached audio codecs to a platform-specific configuration after power-up. When `start_i` is pulsed, it takes the audio controller out of reset over a register-bus master port and reads which codec slots report presence. It then visits the present codecs one at a time, in ascending address order. For each codec it reads the vendor/device identifier through the single-command register pair.

The identifier and codec address are looked up in a built-in match list. On a hit, every verb of the selected table is sent to that codec. Table entries can carry a conditional tag. Such entries, for example front-panel jack pin settings, are sent only while `jack_present_i` is high. The match list and table contents are parameters.

The bus port is a valid/ready request channel with a response channel that carries no ready. A request is presented with `req_valid_o` and held unchanged until `req_ready_i` accepts it, so the bus may stall the sequencer for any number of cycles. Only one request is outstanding. Every request, read or write, is completed by a one-cycle `rsp_valid_i` pulse, and the sequencer always accepts it. `done_o` and `err_o` are plain status levels.

Top module: `codec_init_seq`

## Requirements
- R1: While reset is held and after its release, `done_o`, `err_o` and `req_valid_o` are 0.
- R2: After `start_i`, the first request writes 1 to offset 0x08. The sequencer then reads 0x08 until bit 0 reads 1.
- R3: Offset 0x0E is read once. Bit i of the response, for i below N_CODECS, marks codec address i as present. Present codecs are processed in ascending address order.
- R4: Identifier read for codec c: poll 0x68 until bit 0 (busy) is 0. Write `{c[3:0], 28'h00F0000}` to 0x60. Write 3 to 0x68. Poll 0x68 until bits [1:0] read 2'b10. Read the identifier from 0x64.
- R5: A table is chosen only when both its codec address and its identifier equal the codec's. Among several hits, the lowest table index wins. With no hit, no verb is sent to that codec.
- R6: Each verb is sent the same way. Poll 0x68 until busy is 0. Write the verb to 0x60 with bits [31:28] replaced by the codec address. Write 3 to 0x68. Poll 0x68 until busy is 0 before the next entry.
- R7: An entry is 34 bits: [31:0] verb, [32] conditional tag, [33] end marker. A table stops at the first end marker, or after TBL_DEPTH entries.
- R8: An entry with the conditional tag set is skipped without any bus traffic while `jack_present_i` is 0, and sent while it is 1.
- R9: If POLL_LIMIT consecutive reads in a poll loop do not show the awaited value, `err_o` is set and the sequencer moves to the next codec. If this happens while waiting for the controller-reset bit, it finishes at once.
- R10: `done_o` rises after the last present codec, or after the presence read when no codec is present. It then stays high with no bus request until the next `start_i`. That start clears `done_o` and `err_o`.
- R11: A request that is not accepted keeps valid, write flag, address and data stable. A new request is never issued before the response to the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a run when idle or done |
| jack_present_i | input | 1 | Enables conditional table entries |
| done_o | output | 1 | Run finished |
| err_o | output | 1 | A poll loop timed out during the run |
| req_valid_o | output | 1 | Bus request valid |
| req_ready_i | input | 1 | Bus accepts the request |
| req_write_o | output | 1 | 1 = write, 0 = read |
| req_addr_o | output | 8 | Register byte offset |
| req_wdata_o | output | 32 | Write data |
| rsp_valid_i | input | 1 | Response pulse, one per request |
| rsp_rdata_i | input | 32 | Read data, valid with `rsp_valid_i` |

## Verification
Several presence masks and identifier sets are used. Two codecs that each match separate out the visit order and the address substitution. An identifier that matches only under the wrong address separates a full match from an identifier-only match. Two tables with the same address and identifier expose the priority rule, and a table without an end marker exposes the depth stop. Running the same tables with the jack flag high and then low isolates conditional skipping. A codec that never answers, a controller whose reset bit never sets, and an empty mask distinguish the two timeout outcomes from a clean finish. The bus model stalls `req_ready_i` and varies response latency to exercise back-pressure.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 32;
  localparam int CADDR_W   = 4;
  localparam int ENTRY_W   = 34;
  localparam int END_BIT   = 33;
  localparam int COND_BIT  = 32;

  localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_PRESENT = 8'h0E;
  localparam logic [ADDR_W-1:0] OFS_CMD     = 8'h60;
  localparam logic [ADDR_W-1:0] OFS_RESP    = 8'h64;
  localparam logic [ADDR_W-1:0] OFS_STAT    = 8'h68;

  localparam logic [27:0] ID_VERB_TAIL = 28'h00F0000;

  localparam int DEMO_TABLES = 2;
  localparam int DEMO_DEPTH  = 8;

  typedef enum logic [1:0] {P_IDLE, P_REQ, P_RSP} port_st_t;

  typedef enum logic [4:0] {
    ST_IDLE, ST_CTL_WR, ST_CTL_POLL, ST_PRES_RD, ST_PICK,
    ST_ID_IDLE, ST_ID_CMD, ST_ID_GO, ST_ID_POLL, ST_ID_RD, ST_MATCH,
    ST_V_FETCH, ST_V_IDLE, ST_V_CMD, ST_V_GO, ST_V_POLL, ST_DONE
  } seq_st_t;

  function automatic logic [DEMO_TABLES*DEMO_DEPTH*ENTRY_W-1:0] demo_rom();
    logic [DEMO_TABLES*DEMO_DEPTH*ENTRY_W-1:0] r;
    r = '0;
    for (int t = 0; t < DEMO_TABLES; t++) begin
      for (int e = 0; e < DEMO_DEPTH; e++) begin
        logic stop, cnd;
        logic [31:0] v;
        stop = (t == 0) ? (e == 5) : (e == 3);
        cnd  = (t == 0) ? (e == 3 || e == 4) : (e == 1);
        v    = 32'h01471C00 + 32'(t) * 32'h00100000 + 32'(e) * 32'h00010000 + 32'(e);
        r[(t*DEMO_DEPTH+e)*ENTRY_W +: ENTRY_W] = {stop, cnd, v};
      end
    end
    return r;
  endfunction

  function automatic logic [DEMO_TABLES*CADDR_W-1:0] demo_match_addr();
    return {4'd2, 4'd0};
  endfunction

  function automatic logic [DEMO_TABLES*DATA_W-1:0] demo_match_id();
    return {32'h11D41984, 32'h10EC0262};
  endfunction
endpackage

// File: rtl/seq_bus_port.sv
module seq_bus_port #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_start_i,
  input  logic          op_write_i,
  input  logic [AW-1:0] op_addr_i,
  input  logic [DW-1:0] op_wdata_i,
  output logic          idle_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic          req_valid_o,
  input  logic          req_ready_i,
  output logic          req_write_o,
  output logic [AW-1:0] req_addr_o,
  output logic [DW-1:0] req_wdata_o,
  input  logic          rsp_valid_i,
  input  logic [DW-1:0] rsp_rdata_i
);
  import seq_pkg::*;

  port_st_t      st_q;
  logic          wr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= P_IDLE;
      wr_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      case (st_q)
        P_IDLE: if (op_start_i) begin
          wr_q   <= op_write_i;
          addr_q <= op_addr_i;
          data_q <= op_wdata_i;
          st_q   <= P_REQ;
        end
        P_REQ:   if (req_ready_i) st_q <= P_RSP;
        P_RSP:   if (rsp_valid_i) st_q <= P_IDLE;
        default: st_q <= P_IDLE;
      endcase
    end
  end

  assign req_valid_o = (st_q == P_REQ);
  assign req_write_o = wr_q;
  assign req_addr_o  = addr_q;
  assign req_wdata_o = data_q;
  assign idle_o      = (st_q == P_IDLE);
  assign done_o      = (st_q == P_RSP) && rsp_valid_i;
  assign rdata_o     = rsp_rdata_i;

  // R11: a stalled request is held unchanged
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o)
      && $stable(req_wdata_o) && $stable(req_write_o)))
    else $error("p_req_hold_r11");
endmodule

// File: rtl/seq_poll_timer.sv
module seq_poll_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic tick_i,
  output logic last_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + CW'(1);
  end

  assign last_o = (cnt_q == CW'(LIMIT - 1));

  // R9: the owner never advances the counter past its final count
  p_no_tick_at_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |-> !last_o)
    else $error("p_no_tick_at_last_r9");
endmodule

// File: rtl/seq_codec_match.sv
module seq_codec_match #(
  parameter int N_TABLES = 2,
  parameter int TW       = 1,
  parameter logic [N_TABLES*seq_pkg::CADDR_W-1:0] MATCH_ADDR = '0,
  parameter logic [N_TABLES*seq_pkg::DATA_W-1:0]  MATCH_ID   = '0
) (
  input  logic [seq_pkg::CADDR_W-1:0] caddr_i,
  input  logic [seq_pkg::DATA_W-1:0]  id_i,
  output logic                        hit_o,
  output logic [TW-1:0]               tbl_o
);
  import seq_pkg::*;

  logic [N_TABLES-1:0] row_hit;

  for (genvar t = 0; t < N_TABLES; t++) begin : g_row
    assign row_hit[t] = (MATCH_ADDR[t*CADDR_W +: CADDR_W] == caddr_i)
                     && (MATCH_ID[t*DATA_W +: DATA_W] == id_i);
  end

  always_comb begin
    hit_o = 1'b0;
    tbl_o = '0;
    for (int t = N_TABLES - 1; t >= 0; t--) begin
      if (row_hit[t]) begin
        hit_o = 1'b1;
        tbl_o = TW'(t);
      end
    end
  end
endmodule

// File: rtl/seq_verb_rom.sv
module seq_verb_rom #(
  parameter int N_TABLES  = 2,
  parameter int TBL_DEPTH = 8,
  parameter int TW        = 1,
  parameter int EW        = 4,
  parameter logic [N_TABLES*TBL_DEPTH*seq_pkg::ENTRY_W-1:0] VERB_ROM = '0
) (
  input  logic [TW-1:0] tbl_i,
  input  logic [EW-1:0] ent_i,
  output logic [31:0]   verb_o,
  output logic          cond_o,
  output logic          last_o
);
  import seq_pkg::*;

  localparam int ROWS = N_TABLES * TBL_DEPTH;

  logic [ENTRY_W-1:0] rows [ROWS];
  logic [ENTRY_W-1:0] sel;
  int                 flat;

  for (genvar i = 0; i < ROWS; i++) begin : g_rows
    assign rows[i] = VERB_ROM[i*ENTRY_W +: ENTRY_W];
  end

  always_comb begin
    flat = int'(tbl_i) * TBL_DEPTH + int'(ent_i);
    sel  = '0;
    if (int'(ent_i) < TBL_DEPTH) begin
      for (int i = 0; i < ROWS; i++) begin
        if (i == flat) sel = rows[i];
      end
    end
  end

  assign verb_o = sel[31:0];
  assign cond_o = sel[COND_BIT];
  assign last_o = sel[END_BIT];
endmodule

// File: rtl/codec_init_seq.sv
module codec_init_seq #(
  parameter int N_CODECS   = 3,
  parameter int N_TABLES   = seq_pkg::DEMO_TABLES,
  parameter int TBL_DEPTH  = seq_pkg::DEMO_DEPTH,
  parameter int POLL_LIMIT = 1024,
  parameter logic [N_TABLES*seq_pkg::CADDR_W-1:0] MATCH_ADDR = seq_pkg::demo_match_addr(),
  parameter logic [N_TABLES*seq_pkg::DATA_W-1:0]  MATCH_ID   = seq_pkg::demo_match_id(),
  parameter logic [N_TABLES*TBL_DEPTH*seq_pkg::ENTRY_W-1:0] VERB_ROM = seq_pkg::demo_rom()
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        jack_present_i,
  output logic        done_o,
  output logic        err_o,
  output logic        req_valid_o,
  input  logic        req_ready_i,
  output logic        req_write_o,
  output logic [7:0]  req_addr_o,
  output logic [31:0] req_wdata_o,
  input  logic        rsp_valid_i,
  input  logic [31:0] rsp_rdata_i
);
  import seq_pkg::*;

  localparam int TW = (N_TABLES > 1) ? $clog2(N_TABLES) : 1;
  localparam int EW = $clog2(TBL_DEPTH + 1);

  seq_st_t              st_q;
  logic [N_CODECS-1:0]  pres_q;
  logic [CADDR_W-1:0]   cur_q;
  logic [DATA_W-1:0]    id_q;
  logic [TW-1:0]        tbl_q;
  logic [EW-1:0]        ent_q;
  logic                 done_q, err_q;

  logic                 op_start, op_write, port_idle, op_done;
  logic [ADDR_W-1:0]    op_addr;
  logic [DATA_W-1:0]    op_wdata, op_rdata;
  logic                 bus_state, poll_state, poll_ok, poll_fail;
  logic                 tmr_clr, tmr_tick, tmr_last;
  logic                 pick_hit;
  logic [CADDR_W-1:0]   pick_idx;
  logic [N_CODECS-1:0]  cur_bit;
  logic                 m_hit;
  logic [TW-1:0]        m_tbl;
  logic [31:0]          rom_verb;
  logic                 rom_cond, rom_last, ent_ok;

  // Bus operation selected by the current state
  always_comb begin
    bus_state  = 1'b1;
    poll_state = 1'b0;
    op_write   = 1'b0;
    op_addr    = OFS_STAT;
    op_wdata   = '0;
    case (st_q)
      ST_CTL_WR:  begin op_write = 1'b1; op_addr = OFS_CTRL; op_wdata = 32'h1; end
      ST_CTL_POLL: begin op_addr = OFS_CTRL; poll_state = 1'b1; end
      ST_PRES_RD: op_addr = OFS_PRESENT;
      ST_ID_IDLE, ST_ID_POLL, ST_V_IDLE, ST_V_POLL: poll_state = 1'b1;
      ST_ID_CMD:  begin op_write = 1'b1; op_addr = OFS_CMD; op_wdata = {cur_q, ID_VERB_TAIL}; end
      ST_V_CMD:   begin op_write = 1'b1; op_addr = OFS_CMD; op_wdata = {cur_q, rom_verb[27:0]}; end
      ST_ID_GO, ST_V_GO: begin op_write = 1'b1; op_wdata = 32'h3; end
      ST_ID_RD:   op_addr = OFS_RESP;
      default:    bus_state = 1'b0;
    endcase
  end

  always_comb begin
    case (st_q)
      ST_CTL_POLL: poll_ok = op_rdata[0];
      ST_ID_POLL:  poll_ok = (op_rdata[1:0] == 2'b10);
      default:     poll_ok = !op_rdata[0];
    endcase
  end

  assign op_start  = bus_state && port_idle;
  assign poll_fail = op_done && poll_state && !poll_ok;
  assign tmr_tick  = poll_fail && !tmr_last;
  assign tmr_clr   = op_done && poll_state && (poll_ok || tmr_last);

  // Lowest present codec still pending
  always_comb begin
    pick_hit = 1'b0;
    pick_idx = '0;
    for (int i = N_CODECS - 1; i >= 0; i--) begin
      if (pres_q[i]) begin
        pick_hit = 1'b1;
        pick_idx = CADDR_W'(i);
      end
    end
  end

  assign cur_bit = N_CODECS'(1) << cur_q;
  assign ent_ok  = (ent_q < EW'(TBL_DEPTH));

  seq_bus_port #(.AW(ADDR_W), .DW(DATA_W)) u_port (
    .clk(clk), .rst_n(rst_n),
    .op_start_i(op_start), .op_write_i(op_write), .op_addr_i(op_addr), .op_wdata_i(op_wdata),
    .idle_o(port_idle), .done_o(op_done), .rdata_o(op_rdata),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_write_o(req_write_o),
    .req_addr_o(req_addr_o), .req_wdata_o(req_wdata_o),
    .rsp_valid_i(rsp_valid_i), .rsp_rdata_i(rsp_rdata_i)
  );

  seq_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr_i(tmr_clr), .tick_i(tmr_tick), .last_o(tmr_last)
  );

  seq_codec_match #(.N_TABLES(N_TABLES), .TW(TW), .MATCH_ADDR(MATCH_ADDR), .MATCH_ID(MATCH_ID)) u_match (
    .caddr_i(cur_q), .id_i(id_q), .hit_o(m_hit), .tbl_o(m_tbl)
  );

  seq_verb_rom #(.N_TABLES(N_TABLES), .TBL_DEPTH(TBL_DEPTH), .TW(TW), .EW(EW), .VERB_ROM(VERB_ROM)) u_rom (
    .tbl_i(tbl_q), .ent_i(ent_q), .verb_o(rom_verb), .cond_o(rom_cond), .last_o(rom_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pres_q <= '0;
      cur_q  <= '0;
      id_q   <= '0;
      tbl_q  <= '0;
      ent_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE, ST_DONE: if (start_i) begin
          st_q   <= ST_CTL_WR;
          done_q <= 1'b0;
          err_q  <= 1'b0;
          pres_q <= '0;
        end
        ST_CTL_WR: if (op_done) st_q <= ST_CTL_POLL;
        ST_CTL_POLL: if (op_done) begin
          if (poll_ok) st_q <= ST_PRES_RD;
          else if (tmr_last) begin
            err_q  <= 1'b1;
            done_q <= 1'b1;
            st_q   <= ST_DONE;
          end
        end
        ST_PRES_RD: if (op_done) begin
          pres_q <= op_rdata[N_CODECS-1:0];
          st_q   <= ST_PICK;
        end
        ST_PICK: begin
          if (pick_hit) begin
            cur_q <= pick_idx;
            st_q  <= ST_ID_IDLE;
          end else begin
            done_q <= 1'b1;
            st_q   <= ST_DONE;
          end
        end
        ST_ID_IDLE, ST_ID_POLL, ST_V_IDLE, ST_V_POLL: if (op_done) begin
          if (poll_ok) begin
            case (st_q)
              ST_ID_IDLE: st_q <= ST_ID_CMD;
              ST_ID_POLL: st_q <= ST_ID_RD;
              ST_V_IDLE:  st_q <= ST_V_CMD;
              default: begin
                ent_q <= ent_q + EW'(1);
                st_q  <= ST_V_FETCH;
              end
            endcase
          end else if (tmr_last) begin
            err_q  <= 1'b1;
            pres_q <= pres_q & ~cur_bit;
            st_q   <= ST_PICK;
          end
        end
        ST_ID_CMD: if (op_done) st_q <= ST_ID_GO;
        ST_ID_GO:  if (op_done) st_q <= ST_ID_POLL;
        ST_ID_RD: if (op_done) begin
          id_q <= op_rdata;
          st_q <= ST_MATCH;
        end
        ST_MATCH: begin
          if (m_hit) begin
            tbl_q <= m_tbl;
            ent_q <= '0;
            st_q  <= ST_V_FETCH;
          end else begin
            pres_q <= pres_q & ~cur_bit;
            st_q   <= ST_PICK;
          end
        end
        ST_V_FETCH: begin
          if (!ent_ok || rom_last) begin
            pres_q <= pres_q & ~cur_bit;
            st_q   <= ST_PICK;
          end else if (rom_cond && !jack_present_i) begin
            ent_q <= ent_q + EW'(1);
          end else begin
            st_q <= ST_V_IDLE;
          end
        end
        ST_V_CMD: if (op_done) st_q <= ST_V_GO;
        ST_V_GO:  if (op_done) st_q <= ST_V_POLL;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign err_o  = err_q;

  // R10: once finished, the bus stays quiet
  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !req_valid_o)
    else $error("p_done_quiet_r10");

  // R4 and R6: every command word carries the codec address in bits 31:28
  p_cmd_caddr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_write_o && req_addr_o == OFS_CMD) |-> (req_wdata_o[31:28] == cur_q))
    else $error("p_cmd_caddr_r6");

  // R7: an end marker is never sent as a verb
  p_no_end_sent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_V_CMD) |-> (!rom_last && ent_ok))
    else $error("p_no_end_sent_r7");

  // R8: a tagged entry only heads for the bus when the jack flag was set
  p_cond_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_V_IDLE && $past(st_q) == ST_V_FETCH) |-> ($past(!rom_cond) || $past(jack_present_i)))
    else $error("p_cond_gate_r8");

  // R9: the error flag rises only after the poll counter reached its end
  p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> $past(tmr_last))
    else $error("p_err_cause_r9");
endmodule

// File: tb/test_codec_init_seq.sv
module test_codec_init_seq;
  localparam int NT = 3;
  localparam int TD = 6;
  localparam int NC = 3;
  localparam int PL = 8;

  function automatic logic [31:0] tb_verb(int t, int e);
    return 32'hF7000000 + 32'(t) * 32'h10000 + 32'(e) * 32'h100 + 32'h3C;
  endfunction
  function automatic logic tb_cond(int t, int e);
    return (t == 0 && (e == 1 || e == 2)) || (t == 1 && e == 3);
  endfunction
  function automatic logic tb_end(int t, int e);
    return (t == 0 && e == 4) || (t == 2 && e == 2);
  endfunction
  function automatic logic [3:0] tb_maddr(int t);
    return (t == 0) ? 4'd0 : 4'd2;
  endfunction
  function automatic logic [31:0] tb_mid(int t);
    return (t == 0) ? 32'hA0A00001 : 32'hB2B20002;
  endfunction
  function automatic logic [NT*TD*34-1:0] tb_rom();
    logic [NT*TD*34-1:0] r;
    for (int t = 0; t < NT; t++)
      for (int e = 0; e < TD; e++)
        r[(t*TD+e)*34 +: 34] = {tb_end(t, e), tb_cond(t, e), tb_verb(t, e)};
    return r;
  endfunction
  function automatic logic [NT*4-1:0] tb_addr_list();
    logic [NT*4-1:0] r;
    for (int t = 0; t < NT; t++) r[t*4 +: 4] = tb_maddr(t);
    return r;
  endfunction
  function automatic logic [NT*32-1:0] tb_id_list();
    logic [NT*32-1:0] r;
    for (int t = 0; t < NT; t++) r[t*32 +: 32] = tb_mid(t);
    return r;
  endfunction

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, jack = 1'b0;
  logic done, err, req_valid, req_write, req_ready = 1'b0, rsp_valid = 1'b0;
  logic [7:0]  req_addr;
  logic [31:0] req_wdata, rsp_rdata = '0;

  always #4 clk = ~clk;

  codec_init_seq #(.N_CODECS(NC), .N_TABLES(NT), .TBL_DEPTH(TD), .POLL_LIMIT(PL),
    .MATCH_ADDR(tb_addr_list()), .MATCH_ID(tb_id_list()), .VERB_ROM(tb_rom())) i_codec_init_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .jack_present_i(jack),
    .done_o(done), .err_o(err), .req_valid_o(req_valid), .req_ready_i(req_ready),
    .req_write_o(req_write), .req_addr_o(req_addr), .req_wdata_o(req_wdata),
    .rsp_valid_i(rsp_valid), .rsp_rdata_i(rsp_rdata));

  int total = 0, bad = 0;
  bit finished = 0;
  logic [40:0] exp_q[$];

  // bus/codec model state
  logic [31:0] codec_id [NC];
  logic [2:0]  pres_mask;
  bit ctrl_stuck, ctrl_bit, ctrl_arm;
  int ctrl_cnt, mute;
  bit busy, irv;
  int busy_cnt;
  logic [31:0] cmd, resp;

  task automatic check(string req, logic [40:0] act, logic [40:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic push(bit w, logic [7:0] a, logic [31:0] d);
    exp_q.push_back({w, a, d});
  endtask

  // driver: expected significant transactions of one run
  task automatic expect_run(logic [2:0] mask, bit j, bit cstuck, int mt);
    push(1, 8'h08, 32'h1);
    if (cstuck) return;
    push(0, 8'h0E, 32'h0);
    for (int c = 0; c < NC; c++) begin
      if (mask[c]) begin
        int hit;
        push(1, 8'h60, {4'(c), 28'h00F0000});
        push(1, 8'h68, 32'h3);
        if (c == mt) continue;
        push(0, 8'h64, 32'h0);
        hit = -1;
        for (int t = NT - 1; t >= 0; t--)
          if (tb_maddr(t) == 4'(c) && tb_mid(t) == codec_id[c]) hit = t;
        if (hit >= 0) begin
          for (int e = 0; e < TD; e++) begin
            if (tb_end(hit, e)) break;
            if (tb_cond(hit, e) && !j) continue;
            push(1, 8'h60, {4'(c), tb_verb(hit, e)[27:0]});
            push(1, 8'h68, 32'h3);
          end
        end
      end
    end
  endtask

  // monitor/model: serves the bus, compares logged transactions
  initial begin
    int cyc = 0, dly = 0;
    bit pend = 0, stall = 0;
    logic [31:0] pdata = '0;
    logic [40:0] held = '0;
    forever begin
      @(negedge clk);
      cyc++;
      rsp_valid = 1'b0;
      if (pend) begin
        if (dly == 0) begin rsp_valid = 1'b1; rsp_rdata = pdata; pend = 0; end
        else dly--;
      end
      req_ready = (cyc % 3 != 2);
      #1;
      if (stall) check("R11 held request", {req_valid, req_write, req_addr, req_wdata}, held);
      stall = req_valid && !req_ready;
      held  = {req_valid, req_write, req_addr, req_wdata};
      if (req_valid && req_ready) begin
        logic [40:0] obs;
        bit logit;
        string tag;
        pdata = '0;
        logit = 1'b0;
        if (req_write) begin
          logit = 1'b1;
          obs = {1'b1, req_addr, req_wdata};
          case (req_addr)
            8'h08: begin ctrl_arm = !ctrl_stuck; ctrl_cnt = 2; end
            8'h60: cmd = req_wdata;
            8'h68: if (req_wdata[0]) begin
              busy = 1; busy_cnt = 3; irv = 0;
              resp = (cmd[27:0] == 28'h00F0000) ? codec_id[cmd[31:28]] : 32'h0;
            end
            default: ;
          endcase
        end else begin
          obs = {1'b0, req_addr, 32'h0};
          case (req_addr)
            8'h08: begin
              pdata = {31'h0, ctrl_bit};
              if (ctrl_arm) begin
                if (ctrl_cnt == 0) ctrl_bit = 1; else ctrl_cnt--;
              end
            end
            8'h0E: begin pdata = {29'h0, pres_mask}; logit = 1'b1; end
            8'h64: begin pdata = resp; logit = 1'b1; end
            8'h68: begin
              pdata = {30'h0, irv, busy};
              if (busy) begin
                busy_cnt--;
                if (busy_cnt == 0) begin
                  busy = 0;
                  irv  = (int'(cmd[31:28]) != mute);
                end
              end
            end
            default: ;
          endcase
        end
        if (logit) begin
          case (req_addr)
            8'h08:   tag = "R2 controller reset write";
            8'h0E:   tag = "R3 presence read";
            8'h64:   tag = "R4 identifier read";
            default: tag = "R6 command stream (R5/R8 selection)";
          endcase
          if (exp_q.size() == 0) check({tag, " unexpected"}, obs, 41'h0);
          else check(tag, obs, exp_q.pop_front());
        end
        pend = 1;
        dly  = cyc % 2;
      end
    end
  end

  task automatic run(string name, logic [2:0] mask, bit j, bit cstuck, int mt, bit exp_err);
    bit seen;
    pres_mask = mask; jack = j; ctrl_stuck = cstuck; mute = mt;
    ctrl_bit = 0; ctrl_arm = 0; busy = 0; irv = 0;
    exp_q.delete();
    expect_run(mask, j, cstuck, mt);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R10 start clears done/err", {39'h0, done, err}, 41'h0);
    seen = 0;
    for (int k = 0; k < 20000 && !seen; k++) begin
      @(negedge clk);
      seen = done;
    end
    check({"R10 done reached: ", name}, {40'h0, seen}, 41'h1);
    check({"R9 error flag: ", name}, {40'h0, err}, {40'h0, exp_err});
    check({"R5/R8 all expected traffic seen: ", name}, 41'(exp_q.size()), 41'h0);
    repeat (6) @(negedge clk);
    check({"R10 quiet and held after done: ", name}, {39'h0, req_valid, done}, 41'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    mute = -1; ctrl_stuck = 0; pres_mask = 0;
    for (int c = 0; c < NC; c++) codec_id[c] = '0;
    repeat (3) @(negedge clk);
    check("R1 reset state", {38'h0, done, err, req_valid}, 41'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 idle after reset", {38'h0, done, err, req_valid}, 41'h0);

    // R3/R5/R7: two matching codecs, ascending order, priority, depth stop
    codec_id[0] = 32'hA0A00001; codec_id[1] = 32'h0; codec_id[2] = 32'hB2B20002;
    run("two codecs jack on", 3'b101, 1'b1, 1'b0, -1, 1'b0);
    // R8: tagged entries skipped
    run("two codecs jack off", 3'b101, 1'b0, 1'b0, -1, 1'b0);
    // R5: identifier matches only under the wrong address, unknown id
    codec_id[1] = 32'hDEAD0000; codec_id[2] = 32'hA0A00001;
    run("partial matches", 3'b111, 1'b1, 1'b0, -1, 1'b0);
    // R9: codec 0 never answers, codec 2 still served
    codec_id[2] = 32'hB2B20002;
    run("silent codec", 3'b101, 1'b1, 1'b0, 0, 1'b1);
    // R9: controller reset bit never sets
    run("stuck controller", 3'b101, 1'b1, 1'b1, -1, 1'b1);
    // R10: nothing present
    run("empty mask", 3'b000, 1'b1, 1'b0, -1, 1'b0);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule